// File: doc/BRIEF.md
# Prefix Immediate Extension Unit

This unit lets a short instruction reach a full 16-bit value. A prefix instruction writes one byte into an extension register and marks it pending. The next instruction that is allowed in extended mode then gets a widened operand. An 8-bit immediate becomes the upper extension byte joined to the immediate byte. A signed 8-bit relative offset becomes a full 16-bit displacement. The pending mark lasts for exactly one instruction. It is cleared at that instruction's boundary strobe, whether or not the instruction used it.

The unit also forms the address for the two short-address forms, where a 6-bit field points into either the lowest or the highest 64 words of the space. It flags any instruction that follows a pending prefix but is not allowed in extended mode. The result is combinational from the current instruction's fields. Only the prefix byte and the pending mark are stored.

Top module: `pfx_ext_unit`

## Requirements
- R1: After a synchronous reset, `ext_pend` and `ext_ill` are 0.
- R2: A cycle with `ext_wr` high loads `ext_wdata` into the extension byte and sets `ext_pend` from the next cycle on. A later write before the next boundary replaces the byte.
- R3: A cycle with `instr_end` high and `ext_wr` low clears `ext_pend` on the following cycle, whatever the current instruction was. With both strobes low, `ext_pend` holds.
- R4: When `ext_wr` and `instr_end` are high in the same cycle (the prefix instruction ending), the write wins and `ext_pend` is set.
- R5: In immediate mode (`op_mode`=0), `eff_out` is {extension byte, `imm_in`} when `ext_pend` and `ext_ok` are both 1. Otherwise it is {00H, `imm_in`}.
- R6: In relative mode (`op_mode`=1) without an active extension, `eff_out` = `pc_in` + 1 + sign-extended `imm_in`, a reach of -127 to +128 words from the current address.
- R7: In relative mode with an active extension, `eff_out` = `pc_in` + 1 + {extension byte, `imm_in`} taken as a 16-bit two's complement value, a reach of -32767 to +32768. All targets wrap modulo 65536.
- R8: `op_mode`=2 gives 0000H + `saddr_in`, and `op_mode`=3 gives FFC0H + `saddr_in`. A pending extension has no effect on either.
- R9: When `ext_pend` is 1 and `ext_ok` is 0, `ext_ill` is 1 and the result is formed as if no extension were pending. `ext_ill` is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_wr | input | 1 | Write strobe for the extension byte |
| ext_wdata | input | 8 | Extension byte to store |
| instr_end | input | 1 | Last cycle of the current instruction |
| ext_ok | input | 1 | Current instruction is allowed in extended mode |
| op_mode | input | 2 | 0 immediate, 1 relative, 2 low short address, 3 high short address |
| imm_in | input | 8 | Immediate byte or signed offset |
| saddr_in | input | 6 | Short address field |
| pc_in | input | 16 | Address of the current instruction |
| eff_out | output | 16 | Effective immediate, address or branch target |
| ext_pend | output | 1 | Extension pending for the current instruction |
| ext_ill | output | 1 | Pending extension met an instruction not allowed in extended mode |

## Verification
The checker watches the pending mark's life cycle on every cycle:
- set by a write,
- cleared by a lone boundary,
- held between strobes.

It also checks that:
- the illegal-use flag only rises with a pending mark and a disallowed instruction,
- unextended immediates keep a zero upper byte,
- high short addresses stay in the top 64 words,
- a freshly written byte shows up in the next extended immediate.

Exact arithmetic can only be shown by the bench's scenarios. This covers the edges of both branch reaches, wraparound of targets past either end of the space, and the fallback result on illegal use.

// File: rtl/pfx_ext_pkg.sv
package pfx_ext_pkg;

    typedef enum logic [1:0] {
        MODE_IMM  = 2'd0,
        MODE_REL  = 2'd1,
        MODE_SHLO = 2'd2,
        MODE_SHHI = 2'd3
    } op_mode_e;

    typedef struct packed {
        logic active;
        logic ill;
    } ext_use_t;

    function automatic ext_use_t judge_use(input logic pend, input logic ok);
        ext_use_t u;
        u.active = pend & ok;
        u.ill    = pend & ~ok;
        return u;
    endfunction

endpackage

// File: rtl/pfx_ext_hold.sv
module pfx_ext_hold #(
    parameter int unsigned XW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [XW-1:0] wdata,
    input  logic          boundary,
    output logic          pend,
    output logic [XW-1:0] val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            val  <= '0;
        end else if (wr) begin
            pend <= 1'b1;
            val  <= wdata;
        end else if (boundary) begin
            pend <= 1'b0;
        end
    end
endmodule

// File: rtl/pfx_ext_calc.sv
module pfx_ext_calc
    import pfx_ext_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned BW = 8,
    parameter int unsigned SW = 6,
    parameter bit          HI_SHORT = 1'b1
) (
    input  op_mode_e           mode,
    input  logic               active,
    input  logic [AW-BW-1:0]   xval,
    input  logic [BW-1:0]      imm,
    input  logic [SW-1:0]      saddr,
    input  logic [AW-1:0]      pc,
    output logic [AW-1:0]      eff
);
    localparam int unsigned XW = AW - BW;
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] imm_wide;
    logic [AW-1:0] disp;
    logic [AW-1:0] short_lo;
    logic [AW-1:0] short_hi;

    always_comb begin
        imm_wide = active ? {xval, imm} : {{XW{1'b0}}, imm};
        disp     = active ? {xval, imm} : {{XW{imm[BW-1]}}, imm};
    end

    assign short_lo = {{(AW-SW){1'b0}}, saddr};

    generate
        if (HI_SHORT) begin : g_hi
            assign short_hi = {{(AW-SW){1'b1}}, saddr};
        end else begin : g_nohi
            assign short_hi = short_lo;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_IMM:  eff = imm_wide;
            MODE_REL:  eff = pc + ONE + disp;
            MODE_SHLO: eff = short_lo;
            default:   eff = short_hi;
        endcase
    end
endmodule

// File: rtl/pfx_ext_unit.sv
module pfx_ext_unit
    import pfx_ext_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned BW = 8,
    parameter int unsigned SW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_wr,
    input  logic [AW-BW-1:0] ext_wdata,
    input  logic             instr_end,
    input  logic             ext_ok,
    input  logic [1:0]       op_mode,
    input  logic [BW-1:0]    imm_in,
    input  logic [SW-1:0]    saddr_in,
    input  logic [AW-1:0]    pc_in,
    output logic [AW-1:0]    eff_out,
    output logic             ext_pend,
    output logic             ext_ill
);
    localparam int unsigned XW = AW - BW;

    logic [XW-1:0] xval;
    ext_use_t      use_s;

    pfx_ext_hold #(.XW(XW)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr       (ext_wr),
        .wdata    (ext_wdata),
        .boundary (instr_end),
        .pend     (ext_pend),
        .val      (xval)
    );

    assign use_s   = judge_use(ext_pend, ext_ok);
    assign ext_ill = use_s.ill;

    pfx_ext_calc #(.AW(AW), .BW(BW), .SW(SW), .HI_SHORT(1'b1)) u_calc (
        .mode   (op_mode_e'(op_mode)),
        .active (use_s.active),
        .xval   (xval),
        .imm    (imm_in),
        .saddr  (saddr_in),
        .pc     (pc_in),
        .eff    (eff_out)
    );
endmodule

// File: rtl/pfx_ext_unit_chk.sv
module pfx_ext_unit_chk #(
    parameter int unsigned AW = 16,
    parameter int unsigned BW = 8,
    parameter int unsigned SW = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             ext_wr,
    input logic [AW-BW-1:0] ext_wdata,
    input logic             instr_end,
    input logic             ext_ok,
    input logic [1:0]       op_mode,
    input logic [AW-1:0]    eff_out,
    input logic             ext_pend,
    input logic             ext_ill
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !ext_pend);

    // R2
    wr_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
        ext_wr |=> ext_pend);

    // R2
    wr_value_chk: assert property (@(posedge clk) disable iff (rst)
        ext_wr |=> ((op_mode == 2'd0 && ext_ok) ->
                    eff_out[AW-1:BW] == $past(ext_wdata)));

    // R3
    boundary_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_end && !ext_wr) |=> !ext_pend);

    // R3
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!instr_end && !ext_wr) |=> $stable(ext_pend));

    // R5
    plain_imm_chk: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 2'd0 && !ext_pend) |-> eff_out[AW-1:BW] == '0);

    // R8
    short_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 2'd3) |-> &eff_out[AW-1:SW]);

    // R9
    ill_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ext_ill |-> (ext_pend && !ext_ok));
endmodule

bind pfx_ext_unit pfx_ext_unit_chk #(.AW(AW), .BW(BW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_wr    (ext_wr),
    .ext_wdata (ext_wdata),
    .instr_end (instr_end),
    .ext_ok    (ext_ok),
    .op_mode   (op_mode),
    .eff_out   (eff_out),
    .ext_pend  (ext_pend),
    .ext_ill   (ext_ill)
);

// File: tb/tb_pfx_ext_unit.sv
`timescale 1ns/1ps
module tb_pfx_ext_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_wr = 1'b0;
    logic [7:0]  ext_wdata = '0;
    logic        instr_end = 1'b0;
    logic        ext_ok = 1'b0;
    logic [1:0]  op_mode = '0;
    logic [7:0]  imm_in = '0;
    logic [5:0]  saddr_in = '0;
    logic [15:0] pc_in = '0;
    logic [15:0] eff_out;
    logic        ext_pend;
    logic        ext_ill;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    pfx_ext_unit dut (.*);

    // fields: has_ext, ext, mode, ok, imm, saddr, pc, expected, expected ill
    localparam int NV = 13;
    localparam logic [58:0] VEC [NV] = '{
        {1'b0, 8'h00, 2'd0, 1'b1, 8'h88, 6'h00, 16'h0000, 16'h0088, 1'b0}, // R5
        {1'b1, 8'h3A, 2'd0, 1'b1, 8'h88, 6'h00, 16'h0000, 16'h3A88, 1'b0}, // R5
        {1'b1, 8'h3A, 2'd0, 1'b0, 8'h88, 6'h00, 16'h0000, 16'h0088, 1'b1}, // R9
        {1'b0, 8'h00, 2'd1, 1'b1, 8'h7F, 6'h00, 16'h1000, 16'h1080, 1'b0}, // R6 +128
        {1'b0, 8'h00, 2'd1, 1'b1, 8'h80, 6'h00, 16'h1000, 16'h0F81, 1'b0}, // R6 -127
        {1'b1, 8'hF8, 2'd1, 1'b1, 8'h62, 6'h00, 16'h0000, 16'hF863, 1'b0}, // R7
        {1'b1, 8'h7F, 2'd1, 1'b1, 8'hFF, 6'h00, 16'h1000, 16'h9000, 1'b0}, // R7 +32768
        {1'b1, 8'h80, 2'd1, 1'b1, 8'h00, 6'h00, 16'h8000, 16'h0001, 1'b0}, // R7 -32767
        {1'b0, 8'h00, 2'd1, 1'b1, 8'h10, 6'h00, 16'hFFFF, 16'h0010, 1'b0}, // R6 wrap
        {1'b1, 8'h01, 2'd1, 1'b1, 8'h00, 6'h00, 16'hFF00, 16'h0001, 1'b0}, // R7 wrap
        {1'b0, 8'h00, 2'd2, 1'b0, 8'h00, 6'h2A, 16'h1234, 16'h002A, 1'b0}, // R8
        {1'b1, 8'h12, 2'd3, 1'b1, 8'hAA, 6'h05, 16'h1234, 16'hFFC5, 1'b0}, // R8
        {1'b1, 8'h99, 2'd2, 1'b0, 8'h00, 6'h3F, 16'h0000, 16'h003F, 1'b1}  // R8 R9
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // prefix instruction: write and boundary in the same cycle
    task automatic prefix(input logic [7:0] v, input logic with_end);
        @(negedge clk);
        ext_wr = 1'b1; ext_wdata = v; instr_end = with_end;
        @(negedge clk);
        ext_wr = 1'b0; instr_end = 1'b0;
    endtask

    task automatic finish_instr();
        @(negedge clk);
        instr_end = 1'b1;
        @(negedge clk);
        instr_end = 1'b0;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pend", {15'd0, ext_pend}, 16'd0);
        check("R1 ill", {15'd0, ext_ill}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][58]) prefix(VEC[i][57:50], 1'b1);
            op_mode = VEC[i][49:48]; ext_ok = VEC[i][47]; imm_in = VEC[i][46:39];
            saddr_in = VEC[i][38:33]; pc_in = VEC[i][32:17];
            #1;
            check($sformatf("R5-8 vec%0d eff", i), eff_out, VEC[i][16:1]);
            check($sformatf("R9 vec%0d ill", i), {15'd0, ext_ill}, {15'd0, VEC[i][0]});
            finish_instr();
            check($sformatf("R3 vec%0d clear", i), {15'd0, ext_pend}, 16'd0);
        end

        // R4: write with boundary in the same cycle leaves the mark set
        prefix(8'h5C, 1'b1);
        check("R4 pend", {15'd0, ext_pend}, 16'd1);
        // R3: idle cycles hold the mark
        repeat (3) @(negedge clk);
        check("R3 hold", {15'd0, ext_pend}, 16'd1);
        // R2: second write before boundary replaces the byte
        prefix(8'hC3, 1'b0);
        op_mode = 2'd0; ext_ok = 1'b1; imm_in = 8'h01;
        #1;
        check("R2 replace", eff_out, 16'hC301);
        finish_instr();
        // R3: the next instruction no longer sees the extension
        #1;
        check("R3 consumed", eff_out, 16'h0001);

        // R1: reset mid-pending clears the mark
        prefix(8'h44, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        ext_ok = 1'b0;
        #1;
        check("R1 reset pend", {15'd0, ext_pend}, 16'd0);
        check("R1 reset ill", {15'd0, ext_ill}, 16'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule